// File: doc/BRIEF.md
# Global Branch History Register

This block keeps a compact fingerprint of recent taken control flow for a branch predictor. Every time a qualifying branch retires taken, the stored history moves up by two bit positions. The two bits at the top fall away, and a fixed selection of bits from the branch's source and destination addresses is folded into the low sixteen positions with XOR. The source address is the address of the last byte of the branch instruction. Only the low twenty bits of the source address and the low six bits of the destination address reach the state.

The predictor reads the current history from `hist_o`. To recover from a misprediction, a snapshot strobe copies the live history into a checkpoint register. A restore strobe later writes that checkpoint back into the history. Restore wins over any branch update in the same cycle, so a flush always lands on the saved state.

Top module: `bhr_global_history`

## Requirements
- R1: While reset (`rst_ni` low) is applied, `hist_o` and `ckpt_o` are all zeros, and they stay zero after release until a write happens.
- R2: A qualifying update writes the old history shifted up by two into `hist_o` on the next clock edge. The old top two bits are lost, and destination bits [5:0] are XORed into history bits [5:0].
- R3: On the same update, pairs of source bits are XORed into history bit pairs: src[7:6] into [1:0], src[11:10] into [3:2], src[15:14] into [5:4], src[5:4] into [7:6], src[9:8] into [9:8], src[13:12] into [11:10], src[17:16] into [13:12], and src[19:18] into [15:14].
- R4: Source bits above 19 and destination bits above 5 have no effect on the history.
- R5: Branch kind codes 0 (jump), 1 (conditional), 2 (call) and 3 (return) all update in the same way when `br_valid_i` and `br_taken_i` are both high.
- R6: When `br_taken_i` is low, the history is unchanged, whatever the kind code.
- R7: Kind code 4 (interrupt return) and the reserved codes 5 to 7 leave the history unchanged, even when taken.
- R8: When `br_valid_i` is low, the history is unchanged.
- R9: The contribution to history bits [1:0] from one update appears at [57:56] after 28 further updates. After 29 further updates, the history no longer depends on that branch at all.
- R10: A high `snap_i` copies the current `hist_o` into `ckpt_o` on the next edge. Otherwise `ckpt_o` holds its value.
- R11: A high `restore_i` loads `ckpt_o` into `hist_o` on the next edge, and it takes priority over a qualifying update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| br_valid_i | input | 1 | A branch retires this cycle |
| br_type_i | input | 3 | Branch kind code (see R5, R7) |
| br_taken_i | input | 1 | Branch was taken |
| br_src_i | input | ADDR_W (48) | Address of the last byte of the branch |
| br_dst_i | input | ADDR_W (48) | Branch destination address |
| snap_i | input | 1 | Capture a checkpoint of the history |
| restore_i | input | 1 | Reload the history from the checkpoint |
| hist_o | output | HIST_W (58) | Current history |
| ckpt_o | output | HIST_W (58) | Saved checkpoint |

## Verification
The bench builds the block with its defaults: a 58-bit history and 48-bit addresses. With a 58-bit history, a single marker branch followed by exactly 28 and then 29 zero-address branches brings the top-of-window boundary within reach. The 48-bit addresses leave room above bit 19 of the source and above bit 5 of the destination, so those bits can be toggled to show that they have no effect. A same-cycle restore and update shows which one wins.

// File: rtl/bhr_pkg.sv
package bhr_pkg;

   typedef enum logic [2:0] {
      KIND_JUMP = 3'd0,
      KIND_COND = 3'd1,
      KIND_CALL = 3'd2,
      KIND_RET  = 3'd3,
      KIND_IRET = 3'd4,
      KIND_RSV5 = 3'd5,
      KIND_RSV6 = 3'd6,
      KIND_RSV7 = 3'd7
   } br_kind_e;

   // Bits per update and extent of the folded address fields.
   localparam int unsigned STEP_BITS     = 2;
   localparam int unsigned SRC_LIVE_BITS = 20;
   localparam int unsigned DST_LIVE_BITS = 6;
   localparam int unsigned SCATTER_PAIRS = 8;
   localparam int unsigned MIX_SPAN      = SCATTER_PAIRS * STEP_BITS;

   // Low bit of the source pair folded into history pair k.
   function automatic int unsigned pair_src_lsb(input int unsigned k);
      case (k)
         0:       return 6;
         1:       return 10;
         2:       return 14;
         3:       return 4;
         4:       return 8;
         5:       return 12;
         6:       return 16;
         default: return 18;
      endcase
   endfunction

endpackage

// File: rtl/bhr_kind_filter.sv
module bhr_kind_filter
   import bhr_pkg::*;
(
   input  logic     valid_i,
   input  logic     taken_i,
   input  br_kind_e kind_i,
   output logic     upd_o
);

   logic kind_ok;

   always_comb begin
      unique case (kind_i)
         KIND_JUMP, KIND_COND, KIND_CALL, KIND_RET: kind_ok = 1'b1;
         default:                                   kind_ok = 1'b0;
      endcase
   end

   assign upd_o = valid_i & taken_i & kind_ok;

endmodule

// File: rtl/bhr_fold.sv
module bhr_fold
   import bhr_pkg::*;
#(
   parameter int unsigned HIST_W = 58,
   parameter int unsigned ADDR_W = 48
) (
   input  logic [HIST_W-1:0] hist_i,
   input  logic [ADDR_W-1:0] src_i,
   input  logic [ADDR_W-1:0] dst_i,
   output logic [HIST_W-1:0] nxt_o
);

   localparam int unsigned KEEP_W = HIST_W - STEP_BITS;

   logic [MIX_SPAN-1:0]      src_mix;
   logic [HIST_W-1:0]        shifted;
   logic [HIST_W-1:0]        src_term;
   logic [HIST_W-1:0]        dst_term;

   for (genvar gk = 0; gk < SCATTER_PAIRS; gk++) begin : g_pair
      localparam int unsigned LSB = pair_src_lsb(gk);
      assign src_mix[gk*STEP_BITS +: STEP_BITS] = src_i[LSB +: STEP_BITS];
   end

   assign shifted  = {hist_i[KEEP_W-1:0], {STEP_BITS{1'b0}}};
   assign src_term = {{(HIST_W-MIX_SPAN){1'b0}}, src_mix};
   assign dst_term = {{(HIST_W-DST_LIVE_BITS){1'b0}}, dst_i[DST_LIVE_BITS-1:0]};
   assign nxt_o    = shifted ^ src_term ^ dst_term;

   logic unused_bits;
   assign unused_bits = ^{hist_i[HIST_W-1:KEEP_W], src_i[ADDR_W-1:MIX_SPAN+4],
                          src_i[3:0], dst_i[ADDR_W-1:DST_LIVE_BITS]};

endmodule

// File: rtl/bhr_ckpt.sv
module bhr_ckpt #(
   parameter int unsigned HIST_W = 58
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              snap_i,
   input  logic [HIST_W-1:0] hist_i,
   output logic [HIST_W-1:0] ckpt_o
);

   logic [HIST_W-1:0] ckpt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     ckpt_q <= '0;
      else if (snap_i) ckpt_q <= hist_i;
   end

   assign ckpt_o = ckpt_q;

   p_snap_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snap_i |=> ckpt_o == $past(hist_i));
   p_ckpt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !snap_i |=> $stable(ckpt_o));

endmodule

// File: rtl/bhr_global_history.sv
module bhr_global_history
   import bhr_pkg::*;
#(
   parameter int unsigned HIST_W = 58,
   parameter int unsigned ADDR_W = 48
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              br_valid_i,
   input  logic [2:0]        br_type_i,
   input  logic              br_taken_i,
   input  logic [ADDR_W-1:0] br_src_i,
   input  logic [ADDR_W-1:0] br_dst_i,
   input  logic              snap_i,
   input  logic              restore_i,
   output logic [HIST_W-1:0] hist_o,
   output logic [HIST_W-1:0] ckpt_o
);

   localparam int unsigned TOP_KEEP = HIST_W - MIX_SPAN;

   initial begin : elab_checks
      assert (HIST_W >= MIX_SPAN + STEP_BITS)
         else $error("HIST_W too small for the scatter field");
      assert (HIST_W % STEP_BITS == 0)
         else $error("HIST_W must be a multiple of the step size");
      assert (ADDR_W >= SRC_LIVE_BITS)
         else $error("ADDR_W must cover the folded source bits");
   end

   logic              upd;
   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_nxt;
   logic [HIST_W-1:0] ckpt;

   bhr_kind_filter u_filter (
      .valid_i (br_valid_i),
      .taken_i (br_taken_i),
      .kind_i  (br_kind_e'(br_type_i)),
      .upd_o   (upd)
   );

   bhr_fold #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_fold (
      .hist_i (hist_q),
      .src_i  (br_src_i),
      .dst_i  (br_dst_i),
      .nxt_o  (hist_nxt)
   );

   bhr_ckpt #(.HIST_W(HIST_W)) u_ckpt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .snap_i (snap_i),
      .hist_i (hist_q),
      .ckpt_o (ckpt)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        hist_q <= '0;
      else if (restore_i) hist_q <= ckpt;
      else if (upd)       hist_q <= hist_nxt;
   end

   assign hist_o = hist_q;
   assign ckpt_o = ckpt;

   p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!upd && !restore_i) |=> $stable(hist_o));
   p_not_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !br_taken_i |-> !upd);
   p_iret_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_type_i >= 3'd4) |-> !upd);
   p_upper_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd && !restore_i) |=>
         hist_o[HIST_W-1:MIX_SPAN] == $past(hist_o[TOP_KEEP+MIX_SPAN-STEP_BITS-1:MIX_SPAN-STEP_BITS]));
   p_low_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd && !restore_i) |=> hist_o[1:0] == $past(br_dst_i[1:0] ^ br_src_i[7:6]));
   p_restore_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restore_i |=> hist_o == $past(ckpt_o));

endmodule

// File: tb/bhr_global_history_bench.sv
module bhr_global_history_bench;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned HW = 58;
   localparam int unsigned AW = 48;
   localparam int unsigned NVEC = 10;

   // Stimulus table: valid, kind, taken, source, destination.
   localparam logic        V_VAL [NVEC] = '{1,1,1,1,1,1,1,1,0,1};
   localparam logic [2:0]  V_KND [NVEC] = '{0,1,2,3,1,4,5,7,0,2};
   localparam logic        V_TKN [NVEC] = '{1,1,1,1,0,1,1,1,1,1};
   localparam logic [47:0] V_SRC [NVEC] = '{
      48'h0000_000F_FFF0, 48'h0000_0005_A5C3, 48'h0000_000A_5A3C,
      48'h0000_0001_2345, 48'h0000_000F_FFFF, 48'h0000_0003_3333,
      48'h0000_0007_7777, 48'h0000_000C_CCCC, 48'h0000_0009_9999,
      48'h0000_000B_EEF1};
   localparam logic [47:0] V_DST [NVEC] = '{
      48'h0000_0000_002A, 48'h0000_0000_0015, 48'h0000_0000_003F,
      48'h0000_0000_0011, 48'h0000_0000_003F, 48'h0000_0000_0022,
      48'h0000_0000_0033, 48'h0000_0000_0001, 48'h0000_0000_0030,
      48'h0000_0000_0007};
   localparam string V_REQ [NVEC] = '{"R5","R5","R5","R5","R6","R7","R7","R7","R8","R3"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          br_valid = 1'b0;
   logic [2:0]    br_type = 3'd0;
   logic          br_taken = 1'b0;
   logic [AW-1:0] br_src = '0;
   logic [AW-1:0] br_dst = '0;
   logic          snap = 1'b0;
   logic          restore = 1'b0;
   logic [HW-1:0] hist;
   logic [HW-1:0] ckpt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bhr_global_history #(.HIST_W(HW), .ADDR_W(AW)) u_bhr_global_history (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .br_valid_i (br_valid),
      .br_type_i  (br_type),
      .br_taken_i (br_taken),
      .br_src_i   (br_src),
      .br_dst_i   (br_dst),
      .snap_i     (snap),
      .restore_i  (restore),
      .hist_o     (hist),
      .ckpt_o     (ckpt)
   );

   function automatic logic [HW-1:0] model(input logic [HW-1:0] h,
                                           input logic [AW-1:0] s,
                                           input logic [AW-1:0] d);
      logic [HW-1:0] m;
      m = h << 2;
      m[5:0]   = m[5:0] ^ d[5:0];
      m[1:0]   = m[1:0] ^ s[7:6];
      m[3:2]   = m[3:2] ^ s[11:10];
      m[5:4]   = m[5:4] ^ s[15:14];
      m[7:6]   = m[7:6] ^ s[5:4];
      m[9:8]   = m[9:8] ^ s[9:8];
      m[11:10] = m[11:10] ^ s[13:12];
      m[13:12] = m[13:12] ^ s[17:16];
      m[15:14] = m[15:14] ^ s[19:18];
      return m;
   endfunction

   task automatic check(input string req, input logic [HW-1:0] act, input logic [HW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one cycle of inputs starting at a falling edge; return at the next falling edge.
   task automatic cycle(input logic v, input logic [2:0] k, input logic t,
                        input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input logic sn, input logic rs);
      br_valid = v; br_type = k; br_taken = t; br_src = s; br_dst = d;
      snap = sn; restore = rs;
      @(negedge clk);
      br_valid = 1'b0; snap = 1'b0; restore = 1'b0;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [HW-1:0] exp;
      logic [HW-1:0] saved;
      @(negedge clk);
      do_reset();
      check("R1 hist after reset", hist, '0);
      check("R1 ckpt after reset", ckpt, '0);

      // Table walk
      exp = '0;
      for (int i = 0; i < NVEC; i++) begin
         cycle(V_VAL[i], V_KND[i], V_TKN[i], V_SRC[i], V_DST[i], 1'b0, 1'b0);
         if (V_VAL[i] && V_TKN[i] && V_KND[i] <= 3'd3)
            exp = model(exp, V_SRC[i], V_DST[i]);
         check(V_REQ[i], hist, exp);
      end

      // R2: pure destination fold with shift from a known state
      do_reset();
      cycle(1, 3'd0, 1, '0, 48'h3F, 0, 0);
      cycle(1, 3'd0, 1, '0, 48'h01, 0, 0);
      check("R2 shift and dst fold", hist, 58'h0FD);

      // R3: one source pair at a time lands in its own history pair
      do_reset();
      cycle(1, 3'd2, 1, 48'h4_0000, '0, 0, 0);
      check("R3 src[19:18] to [15:14]", hist, 58'h4000);
      do_reset();
      cycle(1, 3'd2, 1, 48'h10, '0, 0, 0);
      check("R3 src[5:4] to [7:6]", hist, 58'h40);

      // R4: high address bits have no effect
      do_reset();
      cycle(1, 3'd1, 1, 48'hFFFF_FFF0_0000, 48'hFFFF_FFFF_FFC0, 0, 0);
      check("R4 high bits ignored", hist, '0);

      // R9: window boundary
      do_reset();
      cycle(1, 3'd0, 1, '0, 48'h3, 0, 0);
      for (int j = 0; j < 28; j++) cycle(1, 3'd3, 1, '0, '0, 0, 0);
      check("R9 top after 28", hist, {2'b11, 56'h0});
      cycle(1, 3'd3, 1, '0, '0, 0, 0);
      check("R9 gone after 29", hist, '0);

      // R10/R11: snapshot, diverge, restore against a same-cycle update
      do_reset();
      cycle(1, 3'd1, 1, 48'hA_BCDE, 48'h2D, 0, 0);
      saved = model('0, 48'hA_BCDE, 48'h2D);
      cycle(0, 3'd0, 0, '0, '0, 1, 0);
      check("R10 snapshot", ckpt, saved);
      cycle(1, 3'd2, 1, 48'h5_5555, 48'h15, 0, 0);
      check("R10 ckpt holds", ckpt, saved);
      cycle(1, 3'd0, 1, 48'hF_FFFF, 48'h3F, 0, 1);
      check("R11 restore wins", hist, saved);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule